// File: doc/BRIEF.md
# Serial Peripheral Port Controller with Sticky Status

This block is an 8-bit serial peripheral port that a CPU reaches through a small register window. The window has three registers: control, status and data. In master mode the block makes the serial clock from the system clock through a selectable divider. It shifts a byte out on its data-out pin while it shifts a byte in from its data-in pin. In slave mode it follows a serial clock and a select line from outside. Both modes shift the most significant bit first. Clock polarity and clock phase are set by control bits, and all four combinations work.

Three sticky flags report a finished byte, a data write that collided with a running transfer, and a select-line fault seen while the block is master. A flag is never cleared by writing to it. Software clears it with two steps: it reads the status register while the flag is set, and then it makes the access that belongs to that flag. A finished received byte moves into a read buffer, so the next byte can shift in while the old one waits to be read. The transmit path has only one buffer: a data write goes straight into the shift register.

Top module: `spi_port_ctrl`

## Requirements
- R1: After reset the control register and the status register read 0x00, and the clock, data-out and data-in drivers are all disabled.
- R2: The register window decodes address 0 as control, 1 as status and 2 as data. The control bits are: bit 0 enable, bit 1 master, bit 2 clock polarity, bit 3 clock phase, bits 5:4 rate code. In master mode the serial clock period is 2, 4, 16 or 32 system clocks for rate codes 0, 1, 2 and 3, and the clock rests at the polarity level between transfers.
- R3: Bytes shift most significant bit first. With phase 0 the data is sampled on the leading clock edge, and with phase 1 on the trailing edge. All four polarity and phase combinations work.
- R4: A data read returns the last completed received byte. That value holds while the next byte is shifting in.
- R5: Status bit 7 (done) sets at the end of every 8-bit transfer.
- R6: Done clears when the status register is read with done set and a data read or data write follows. A data access without that earlier status read leaves done set.
- R7: A data write while a transfer is running sets status bit 6 (collision). The written byte is discarded, and the running transfer finishes with its original byte.
- R8: The collision flag clears by the same sequence: a status read with the flag set, then a data access.
- R9: The select input going low while the block is enabled as master sets status bit 4 (fault). The fault aborts the transfer with no done, clears control bits 0 and 1, and releases the clock and data-out drivers.
- R10: The fault flag clears only when the status register is read with the flag set and a control write follows. Data accesses do not clear it, and neither does a control write without the earlier status read.
- R11: Status bits 5 and 3:0 always read 0, and writes to the status register change no flag.
- R12: In slave mode the block shifts in on its data-in pin and drives its miso output, timed by the external clock while select is low. The rate code has no effect in this mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during a read strobe |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock driver enable |
| mosi_o | output | 1 | Serial data out (master) |
| mosi_oe | output | 1 | Serial data-out driver enable |
| miso_i | input | 1 | Serial data in (master) |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_i | input | 1 | Serial data in (slave) |
| ss_n_i | input | 1 | Active-low select input |
| miso_o | output | 1 | Serial data out (slave) |
| miso_oe | output | 1 | Slave data-out driver enable |

## Verification
The cases that are hardest to reach from the ports are events that land inside a running transfer: a collision write and a select fault. The data-read view of the previous byte during the next shift belongs here too. The bench reaches them by starting a transfer and waiting a number of cycles worked out from the selected divider. It then makes the colliding write or pulls the select line low while the clock is still toggling. Data-out is looped back, inverted, onto data-in. As a result every received byte is a known function of the byte sent, and a discarded write shows up at once.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int STAT_DONE_BIT = 7;
  localparam int STAT_WCOL_BIT = 6;
  localparam int STAT_MODF_BIT = 4;

  localparam int FLG_DONE = 0;
  localparam int FLG_WCOL = 1;
  localparam int FLG_MODF = 2;
  localparam int FLG_N    = 3;

  typedef struct packed {
    logic [1:0] rate;
    logic       cpha;
    logic       cpol;
    logic       master;
    logic       en;
  } ctrl_t;

  // serial clock period in system clocks for a rate code
  function automatic int unsigned sck_period(input logic [1:0] code);
    return code[1] ? (32'd16 << code[0]) : (32'd2 << code[0]);
  endfunction

  function automatic int unsigned sck_half(input logic [1:0] code);
    return sck_period(code) >> 1;
  endfunction

endpackage

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       abort,
  input  logic       cpol,
  input  logic [1:0] rate,
  output logic       sck,
  output logic       lead_ev,
  output logic       trail_ev,
  output logic       last_ev,
  output logic       running
);
  localparam int TOGGLES = 2 * DATA_W;
  localparam int TOG_W   = $clog2(TOGGLES);
  localparam int CNT_W   = 5;

  logic [CNT_W-1:0] cnt_q;
  logic [TOG_W-1:0] tog_q;
  logic             run_q;
  logic             sck_q;
  logic [CNT_W-1:0] half_m1;
  logic             tick;

  assign half_m1  = CNT_W'(sck_half(rate) - 1);
  assign tick     = run_q && (cnt_q >= half_m1);
  assign lead_ev  = tick && !tog_q[0];
  assign trail_ev = tick && tog_q[0];
  assign last_ev  = trail_ev && (tog_q == TOG_W'(TOGGLES - 1));
  assign sck      = sck_q;
  assign running  = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      tog_q <= '0;
      sck_q <= 1'b0;
    end else if (abort) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      tog_q <= '0;
      sck_q <= cpol;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      tog_q <= '0;
      sck_q <= cpol;
    end else if (run_q) begin
      if (tick) begin
        cnt_q <= '0;
        sck_q <= ~sck_q;
        tog_q <= tog_q + 1'b1;
        if (last_ev) run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      sck_q <= cpol;
    end
  end
endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              cpha,
  input  logic              drive_ev,
  input  logic              sample_ev,
  input  logic              rx_in,
  output logic              out_bit,
  output logic [DATA_W-1:0] rx_next
);
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_q;
  logic              out_q;

  assign rx_next = sample_ev ? {rx_q[DATA_W-2:0], rx_in} : rx_q;
  assign out_bit = out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      out_q <= 1'b0;
    end else if (load) begin
      if (!cpha) begin
        out_q <= load_data[DATA_W-1];
        tx_q  <= load_data << 1;
      end else begin
        tx_q  <= load_data;
      end
    end else begin
      if (drive_ev) begin
        out_q <= tx_q[DATA_W-1];
        tx_q  <= tx_q << 1;
      end
      rx_q <= rx_next;
    end
  end
endmodule

// File: rtl/spi_port_flags.sv
module spi_port_flags
  import spi_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLG_N-1:0] set_v,
  input  logic             stat_rd,
  input  logic             data_acc,
  input  logic             ctrl_wr,
  output logic [FLG_N-1:0] flag_o
);
  for (genvar i = 0; i < FLG_N; i++) begin : g_flag
    logic flag_q;
    logic arm_q;
    logic clr_src;

    if (i == FLG_MODF) begin : g_ctrl_clr
      assign clr_src = ctrl_wr;
    end else begin : g_data_clr
      assign clr_src = data_acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
        arm_q  <= 1'b0;
      end else if (set_v[i]) begin
        flag_q <= 1'b1;
        arm_q  <= 1'b0;
      end else if (arm_q && clr_src) begin
        flag_q <= 1'b0;
        arm_q  <= 1'b0;
      end else if (stat_rd && flag_q) begin
        arm_q  <= 1'b1;
      end
    end

    assign flag_o[i] = flag_q;
  end
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sck_o,
  output logic              sck_oe,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              ss_n_i,
  output logic              miso_o,
  output logic              miso_oe
);
  localparam int CTRL_W = $bits(ctrl_t);
  localparam int BIT_W  = $clog2(DATA_W);

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] rx_buf_q;
  logic [2:0]        sync_q [SYNC_STAGES];
  logic              sck_s, mosi_s, ss_n_s, sck_prev_q;

  // bus decode
  logic ctrl_wr, stat_rd, data_wr, data_rd;
  assign ctrl_wr = bus_sel && bus_wr  && (bus_addr == ADDR_CTRL);
  assign stat_rd = bus_sel && !bus_wr && (bus_addr == ADDR_STAT);
  assign data_wr = bus_sel && bus_wr  && (bus_addr == ADDR_DATA);
  assign data_rd = bus_sel && !bus_wr && (bus_addr == ADDR_DATA);

  // input synchronizers for slave pins
  for (genvar k = 0; k < SYNC_STAGES; k++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[k] <= 3'b111;
      else if (k == 0) sync_q[k] <= {ss_n_i, mosi_i, sck_i};
      else sync_q[k] <= sync_q[(k == 0) ? 0 : k-1];
    end
  end
  assign {ss_n_s, mosi_s, sck_s} = sync_q[SYNC_STAGES-1];

  // named internal events
  logic master_mode, slave_sel, xfer_busy;
  logic evt_modf, evt_wcol, evt_start, evt_done;
  logic ctrl_cpol, flag_done, flag_wcol, flag_modf;

  logic m_sck, m_lead, m_trail, m_last, m_run;
  logic s_lead, s_trail, s_done, s_busy_q;
  logic [BIT_W-1:0] s_cnt_q;
  logic lead_ev, trail_ev, drive_ev, sample_ev, rx_in, out_bit;
  logic [DATA_W-1:0] rx_next;
  logic [FLG_N-1:0] flags;

  assign master_mode = ctrl_q.en && ctrl_q.master;
  assign slave_sel   = ctrl_q.en && !ctrl_q.master && !ss_n_s;
  assign ctrl_cpol   = ctrl_q.cpol;
  assign xfer_busy   = m_run || s_busy_q;
  assign evt_modf    = master_mode && !ss_n_s;
  assign evt_wcol    = data_wr && xfer_busy;
  assign evt_start   = data_wr && !xfer_busy && master_mode && !evt_modf;
  assign evt_done    = (m_last && !evt_modf) || s_done;

  spi_port_clkgen #(.DATA_W(DATA_W)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (evt_start),
    .abort    (evt_modf || !master_mode),
    .cpol     (ctrl_q.cpol),
    .rate     (ctrl_q.rate),
    .sck      (m_sck),
    .lead_ev  (m_lead),
    .trail_ev (m_trail),
    .last_ev  (m_last),
    .running  (m_run)
  );

  // slave edge detection on synchronized clock
  assign s_lead  = slave_sel && (sck_prev_q == ctrl_q.cpol) && (sck_s != ctrl_q.cpol);
  assign s_trail = slave_sel && (sck_prev_q != ctrl_q.cpol) && (sck_s == ctrl_q.cpol);
  assign s_done  = s_trail && (s_cnt_q == BIT_W'(DATA_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q <= 1'b1;
      s_cnt_q    <= '0;
      s_busy_q   <= 1'b0;
    end else begin
      sck_prev_q <= sck_s;
      if (!slave_sel) begin
        s_cnt_q  <= '0;
        s_busy_q <= 1'b0;
      end else begin
        if (s_lead) s_busy_q <= 1'b1;
        if (s_trail) s_cnt_q <= s_cnt_q + 1'b1;
        if (s_done) begin
          s_busy_q <= 1'b0;
          s_cnt_q  <= '0;
        end
      end
    end
  end

  assign lead_ev   = master_mode ? m_lead  : s_lead;
  assign trail_ev  = master_mode ? m_trail : s_trail;
  assign drive_ev  = ctrl_q.cpha ? lead_ev  : trail_ev;
  assign sample_ev = ctrl_q.cpha ? trail_ev : lead_ev;
  assign rx_in     = master_mode ? miso_i : mosi_s;

  spi_port_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (data_wr && !xfer_busy),
    .load_data (bus_wdata),
    .cpha      (ctrl_q.cpha),
    .drive_ev  (drive_ev),
    .sample_ev (sample_ev),
    .rx_in     (rx_in),
    .out_bit   (out_bit),
    .rx_next   (rx_next)
  );

  logic [FLG_N-1:0] flag_set;
  always_comb begin
    flag_set           = '0;
    flag_set[FLG_DONE] = evt_done;
    flag_set[FLG_WCOL] = evt_wcol;
    flag_set[FLG_MODF] = evt_modf;
  end

  spi_port_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_v    (flag_set),
    .stat_rd  (stat_rd),
    .data_acc (data_wr || data_rd),
    .ctrl_wr  (ctrl_wr),
    .flag_o   (flags)
  );
  assign flag_done = flags[FLG_DONE];
  assign flag_wcol = flags[FLG_WCOL];
  assign flag_modf = flags[FLG_MODF];

  // control and receive buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      rx_buf_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (evt_modf) begin
        ctrl_q.en     <= 1'b0;
        ctrl_q.master <= 1'b0;
      end
      if (evt_done) rx_buf_q <= rx_next;
    end
  end

  logic [DATA_W-1:0] stat_word;
  always_comb begin
    stat_word                = '0;
    stat_word[STAT_DONE_BIT] = flag_done;
    stat_word[STAT_WCOL_BIT] = flag_wcol;
    stat_word[STAT_MODF_BIT] = flag_modf;
  end

  always_comb begin
    case (bus_addr)
      ADDR_CTRL: bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      ADDR_STAT: bus_rdata = stat_word;
      ADDR_DATA: bus_rdata = rx_buf_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign sck_o   = m_sck;
  assign sck_oe  = master_mode;
  assign mosi_o  = out_bit;
  assign mosi_oe = master_mode;
  assign miso_o  = out_bit;
  assign miso_oe = slave_sel;
endmodule

// File: rtl/spi_port_ctrl_chk.sv
module spi_port_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              sck_o,
  input logic              sck_oe,
  input logic              mosi_oe,
  input logic              ctrl_cpol,
  input logic              xfer_busy,
  input logic              evt_done,
  input logic              evt_wcol,
  input logic              evt_modf,
  input logic              flag_done,
  input logic              flag_wcol,
  input logic              flag_modf
);
  // R11
  stat_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 2'd1) |-> (bus_rdata[5] == 1'b0 && bus_rdata[3:0] == 4'd0));

  // R9
  modf_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_modf |=> (!sck_oe && !mosi_oe));

  // R9
  modf_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_modf) |-> $past(evt_modf));

  // R5
  done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_done) |-> $past(evt_done));

  // R7
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wcol |=> flag_wcol);

  // R2
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_oe && !xfer_busy && $stable(ctrl_cpol)) |-> (sck_o == ctrl_cpol));
endmodule

bind spi_port_ctrl spi_port_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .sck_o     (sck_o),
  .sck_oe    (sck_oe),
  .mosi_oe   (mosi_oe),
  .ctrl_cpol (ctrl_cpol),
  .xfer_busy (xfer_busy),
  .evt_done  (evt_done),
  .evt_wcol  (evt_wcol),
  .evt_modf  (evt_modf),
  .flag_done (flag_done),
  .flag_wcol (flag_wcol),
  .flag_modf (flag_modf)
);

// File: tb/spi_port_ctrl_test.sv
module spi_port_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic       sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
  wire        miso_i = ~mosi_o;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  spi_port_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .sck_i(sck_i), .mosi_i(mosi_i), .ss_n_i(ss_n_i),
    .miso_o(miso_o), .miso_oe(miso_oe)
  );

  task automatic check(input string what, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  function automatic int period_of(input int code);
    return 1 << (code + 1 + (code >> 1));
  endfunction

  task automatic run_master(input logic [7:0] tx, input bit cpol, input bit cpha, input int rate);
    logic [7:0] cap, rd;
    int tog, last, bad, per;
    logic prev;
    bus_write(2'd0, 8'((rate << 4) | (cpha << 3) | (cpol << 2) | 3));
    @(negedge clk);
    check("R2 clock rests at polarity", sck_o, cpol);
    bus_write(2'd2, tx);
    prev = cpol; tog = 0; last = 0; bad = 0; cap = 8'd0; per = 0;
    for (int c = 1; c < 3000 && tog < 16; c++) begin
      @(negedge clk);
      if (sck_o !== prev) begin
        if (tog == 1) per = 2 * (c - last);
        if (tog > 0 && 2 * (c - last) != period_of(rate)) bad++;
        if ((prev == cpol) != cpha) cap = {cap[6:0], mosi_o};
        prev = sck_o; last = c; tog++;
      end
    end
    repeat (2) @(negedge clk);
    check("R2 edge count", tog, 16);
    check("R2 clock period", per, period_of(rate));
    check("R2 uneven half periods", bad, 0);
    check("R3 bits on data-out, MSB first", cap, tx);
    bus_read(2'd1, rd);
    check("R5 done after byte", rd, 8'h80);
    bus_read(2'd2, rd);
    check("R4 received byte", rd, 8'(~tx));
    bus_read(2'd1, rd);
    check("R6 done cleared by status then data read", rd, 8'h00);
  endtask

  task automatic run_slave(input logic [7:0] dut_tx, input logic [7:0] host_tx, input bit cpol, input int rate);
    logic [7:0] capm, rd;
    bus_write(2'd0, 8'((rate << 4) | (cpol << 2) | 1));
    bus_write(2'd2, dut_tx);
    sck_i = cpol;
    repeat (3) @(negedge clk);
    ss_n_i = 1'b0;
    repeat (8) @(negedge clk);
    check("R12 slave drives miso when selected", miso_oe, 1);
    check("R12 master drivers off in slave mode", sck_oe, 0);
    capm = 8'd0;
    for (int b = 7; b >= 0; b--) begin
      mosi_i = host_tx[b];
      repeat (8) @(negedge clk);
      capm = {capm[6:0], miso_o};
      sck_i = ~cpol;
      repeat (8) @(negedge clk);
      sck_i = cpol;
    end
    repeat (8) @(negedge clk);
    check("R12 slave miso byte", capm, dut_tx);
    bus_read(2'd1, rd);
    check("R12 slave done flag", rd, 8'h80);
    bus_read(2'd2, rd);
    check("R12 slave received byte", rd, host_tx);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(2'd1, rd);
    check("R6 slave done cleared", rd, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    bus_read(2'd0, rd);
    check("R1 control at reset", rd, 8'h00);
    bus_read(2'd1, rd);
    check("R1 status at reset", rd, 8'h00);
    check("R1 drivers off at reset", {sck_oe, mosi_oe, miso_oe}, 3'b000);

    // R11 status writes ignored, spare bits zero
    bus_write(2'd1, 8'hFF);
    bus_read(2'd1, rd);
    check("R11 status write ignored", rd, 8'h00);

    // R2 R3 sweep over modes and rates
    for (int m = 0; m < 4; m++)
      for (int r = 0; r < 4; r++)
        run_master(8'(8'h3C ^ (m * 67 + r * 29)), m[1], m[0], r);

    // R6 data access without earlier status read keeps done
    run_master(8'h96, 1'b0, 1'b0, 0);
    bus_write(2'd2, 8'h5B);
    repeat (40) @(negedge clk);
    bus_read(2'd2, rd);
    check("R4 received byte 5B", rd, 8'hA4);
    bus_read(2'd1, rd);
    check("R6 data read alone keeps done", rd, 8'h80);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, rd);
    check("R11 status write keeps done", rd, 8'h80);
    bus_read(2'd2, rd);
    bus_read(2'd1, rd);
    check("R6 done cleared after sequence", rd, 8'h00);

    // R4 R7 R8 collision in mid-transfer at rate 3
    bus_write(2'd0, 8'h33);
    bus_write(2'd2, 8'hC3);
    repeat (100) @(negedge clk);
    bus_read(2'd2, rd);
    check("R4 read buffer holds previous byte", rd, 8'hA4);
    bus_write(2'd2, 8'h0F);
    bus_read(2'd1, rd);
    check("R7 collision flag set mid-transfer", rd, 8'h40);
    repeat (600) @(negedge clk);
    bus_read(2'd1, rd);
    check("R7 done and collision", rd, 8'hC0);
    bus_read(2'd2, rd);
    check("R7 colliding write discarded", rd, 8'h3C);
    bus_read(2'd1, rd);
    check("R8 collision cleared by sequence", rd, 8'h00);

    // R9 R10 mode fault
    bus_write(2'd0, 8'h37);
    bus_write(2'd2, 8'h5A);
    repeat (60) @(negedge clk);
    ss_n_i = 1'b0;
    repeat (6) @(negedge clk);
    check("R9 drivers released on fault", {sck_oe, mosi_oe}, 2'b00);
    bus_read(2'd0, rd);
    check("R9 enable and master cleared", rd, 8'h34);
    ss_n_i = 1'b1;
    repeat (700) @(negedge clk);
    bus_read(2'd1, rd);
    check("R9 fault flag, no done", rd, 8'h10);
    bus_read(2'd2, rd);
    bus_write(2'd2, 8'h00);
    bus_read(2'd1, rd);
    check("R10 data accesses keep fault", rd, 8'h10);
    bus_write(2'd0, 8'h00);
    bus_read(2'd1, rd);
    check("R10 fault cleared by control write", rd, 8'h00);

    bus_write(2'd0, 8'h03);
    ss_n_i = 1'b0;
    repeat (6) @(negedge clk);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    bus_write(2'd0, 8'h00);
    bus_read(2'd1, rd);
    check("R10 control write without status read keeps fault", rd, 8'h10);
    bus_write(2'd0, 8'h00);
    bus_read(2'd1, rd);
    check("R10 fault cleared after sequence", rd, 8'h00);

    // R12 slave mode with two rate codes
    run_slave(8'hA5, 8'h6E, 1'b0, 0);
    run_slave(8'h5C, 8'hB1, 1'b1, 3);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule